// File: doc/BRIEF.md
# Four-Voice Wavetable Phase Mixer

This block produces one stereo audio sample each time its sample strobe fires, built from four wavetable voices. Every voice owns a 32-bit phase accumulator and a 32-bit step register, both held in 9.15 fixed-point form with 24 meaningful bits. On a strobe each voice adds its step to its phase. The nine integer bits of the new phase select one byte from a 512-entry table bank. The four bytes are averaged, and the average drives both stereo outputs.

Software programs the block through a byte-wide register window. Each 32-bit register occupies four consecutive addresses, most significant byte first. A two-bit mode field gates generation, so the accumulators advance only in play mode. The table storage lives outside the block. The block drives one table address per voice and receives the selected byte back in the same cycle. The first two voices share bank 0 and the last two share bank 1.

Top module: `wavemix4`

## Requirements
- R1: After reset all eight voice registers, the mode field, `left`, `right` and `out_valid` read as zero.
- R2: Voice v has its phase at byte addresses 0x10+8v to 0x13+8v and its step at 0x14+8v to 0x17+8v. The lowest address of each holds bits 31:24. A byte read returns the stored byte, and a write replaces only that byte.
- R3: The mode field sits at address 0x01 and holds two bits. Written bits 7:2 are dropped and read back as 0. Generation runs only while the field equals 2.
- R4: On a strobe in play mode every phase becomes (phase + step) modulo 2^32, and software can read the new value afterwards.
- R5: Table address field v of `tbl_addr` is 10 bits wide. Bit 9 is the bank, equal to v/2. Bits 8:0 are phase bits 23:15. Phase bits 31:24 and 14:0 do not affect the address.
- R6: A strobe sampled at clock edge E in play mode raises `out_valid` for exactly the one cycle after edge E+1. In that cycle `left` and `right` both equal the sum of the four table bytes fetched with the updated phases, shifted right by 2. Between pulses both outputs hold their value.
- R7: A strobe while the mode field is not 2 leaves all phases, `left`, `right` and `out_valid` unchanged.
- R8: A step write between strobes changes no table address and no output. The next strobe uses the new step.
- R9: Reads of addresses outside the mode field and the voice registers return 0. Writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample strobe, one cycle per output sample |
| reg_we | input | 1 | Byte write enable for the register window |
| reg_addr | input | 8 | Register window byte address (read and write) |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte, combinational from `reg_addr` |
| tbl_addr | output | 40 | Four 10-bit table addresses, voice 0 in bits 9:0 |
| tbl_data | input | 32 | Four table bytes, voice 0 in bits 7:0 |
| left | output | 8 | Left output sample |
| right | output | 8 | Right output sample |
| out_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The assertions cover the following on every cycle:
- the two-cycle link between a play-mode strobe and the `out_valid` pulse, in both directions;
- the outputs staying frozen between pulses;
- the table addresses holding still when neither a strobe nor a register write occurs.

Other properties need a reference model, so only the bench scenarios show them:
- the numeric value of the mix;
- the bank of each voice;
- the 32-bit wrap of the phase;
- big-endian byte placement;
- masking of the mode field.

The bench checks these against its own model of phases and table contents.

// File: rtl/wm_pkg.sv
package wm_pkg;
    localparam int REG_BYTES  = 4;
    localparam int REG_W      = 8 * REG_BYTES;
    localparam int LANE_W     = $clog2(REG_BYTES);
    localparam int OFF_W      = LANE_W + 1;
    localparam int VOICE_SPAN = 2 * REG_BYTES;
    localparam int MODE_W     = 2;

    typedef struct packed {
        logic [REG_W-1:0] phase;
        logic [REG_W-1:0] step;
    } voice_regs_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              pend;
    } ctrl_regs_t;
endpackage

// File: rtl/wm_voice.sv
module wm_voice
    import wm_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BASE    = 16,
    parameter int FRAC_W  = 15,
    parameter int IDX_W   = 9,
    parameter int BANK_W  = 1,
    parameter int BANK    = 0,
    localparam int TADDR_W = BANK_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    output logic [REG_W-1:0]   phase_o,
    output logic [REG_W-1:0]   step_o,
    output logic [TADDR_W-1:0] taddr_o
);
    voice_regs_t       v_d, v_q;
    logic              hit;
    logic [OFF_W-1:0]  offs;
    logic [LANE_W-1:0] lane;

    always_comb begin
        hit  = (int'(wr_addr) >= BASE) && (int'(wr_addr) < BASE + VOICE_SPAN);
        offs = OFF_W'(wr_addr - ADDR_W'(BASE));
        lane = ~offs[LANE_W-1:0];
        v_d  = v_q;
        if (adv) begin
            v_d.phase = v_q.phase + v_q.step;
        end
        if (wr_en && hit) begin
            if (offs[OFF_W-1]) begin
                v_d.step[{lane, 3'b000} +: 8] = wr_data;
            end else begin
                v_d.phase[{lane, 3'b000} +: 8] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
    end

    assign phase_o = v_q.phase;
    assign step_o  = v_q.step;
    assign taddr_o = {BANK_W'(BANK), v_q.phase[FRAC_W +: IDX_W]};
endmodule

// File: rtl/wm_readback.sv
module wm_readback
    import wm_pkg::*;
#(
    parameter int NUM_VOICES = 4,
    parameter int ADDR_W     = 8,
    parameter int VOICE_BASE = 16,
    parameter int MODE_ADDR  = 1
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [MODE_W-1:0]           mode,
    input  logic [NUM_VOICES*REG_W-1:0] phase_all,
    input  logic [NUM_VOICES*REG_W-1:0] step_all,
    output logic [7:0]                  rdata
);
    always_comb begin
        logic [OFF_W-1:0]  offs;
        logic [LANE_W-1:0] lane;
        logic [REG_W-1:0]  word;
        int                base;
        rdata = '0;
        offs  = '0;
        lane  = '0;
        word  = '0;
        base  = 0;
        if (addr == ADDR_W'(MODE_ADDR)) begin
            rdata = {{(8-MODE_W){1'b0}}, mode};
        end
        for (int v = 0; v < NUM_VOICES; v++) begin
            base = VOICE_BASE + v * VOICE_SPAN;
            if ((int'(addr) >= base) && (int'(addr) < base + VOICE_SPAN)) begin
                offs  = OFF_W'(addr - ADDR_W'(base));
                lane  = ~offs[LANE_W-1:0];
                word  = offs[OFF_W-1] ? step_all[v*REG_W +: REG_W]
                                      : phase_all[v*REG_W +: REG_W];
                rdata = word[{lane, 3'b000} +: 8];
            end
        end
    end
endmodule

// File: rtl/wm_mix.sv
module wm_mix #(
    parameter int NUM_VOICES = 4,
    parameter int SMP_W      = 8,
    localparam int SHIFT     = $clog2(NUM_VOICES),
    localparam int SUM_W     = SMP_W + SHIFT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        capture,
    input  logic [NUM_VOICES*SMP_W-1:0] samples,
    output logic [SMP_W-1:0]            left,
    output logic [SMP_W-1:0]            right,
    output logic                        valid
);
    typedef struct packed {
        logic [SMP_W-1:0] mix;
        logic             valid;
    } mix_regs_t;

    mix_regs_t        m_d, m_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = '0;
        for (int v = 0; v < NUM_VOICES; v++) begin
            sum = sum + SUM_W'(samples[v*SMP_W +: SMP_W]);
        end
        m_d       = m_q;
        m_d.valid = capture;
        if (capture) begin
            m_d.mix = sum[SHIFT +: SMP_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign left  = m_q.mix;
    assign right = m_q.mix;
    assign valid = m_q.valid;
endmodule

// File: rtl/wavemix4.sv
module wavemix4
    import wm_pkg::*;
#(
    parameter int NUM_VOICES      = 4,
    parameter int VOICES_PER_BANK = 2,
    parameter int ADDR_W          = 8,
    parameter int SMP_W           = 8,
    parameter int FRAC_W          = 15,
    parameter int IDX_W           = 9,
    parameter int VOICE_BASE      = 'h10,
    parameter int MODE_ADDR       = 'h01,
    parameter int MODE_PLAY       = 2,
    localparam int NUM_BANKS      = NUM_VOICES / VOICES_PER_BANK,
    localparam int BANK_W         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int TADDR_W        = BANK_W + IDX_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          reg_we,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [7:0]                    reg_wdata,
    output logic [7:0]                    reg_rdata,
    output logic [NUM_VOICES*TADDR_W-1:0] tbl_addr,
    input  logic [NUM_VOICES*SMP_W-1:0]   tbl_data,
    output logic [SMP_W-1:0]              left,
    output logic [SMP_W-1:0]              right,
    output logic                          out_valid
);
    ctrl_regs_t                    ctl_d, ctl_q;
    logic                          play;
    logic                          adv;
    logic [NUM_VOICES*REG_W-1:0]   phase_all;
    logic [NUM_VOICES*REG_W-1:0]   step_all;

    assign play = (ctl_q.mode == MODE_W'(MODE_PLAY));
    assign adv  = tick && play;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.pend = adv;
        if (reg_we && (reg_addr == ADDR_W'(MODE_ADDR))) begin
            ctl_d.mode = reg_wdata[MODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar gv = 0; gv < NUM_VOICES; gv++) begin : g_voice
        wm_voice #(
            .ADDR_W (ADDR_W),
            .BASE   (VOICE_BASE + gv * VOICE_SPAN),
            .FRAC_W (FRAC_W),
            .IDX_W  (IDX_W),
            .BANK_W (BANK_W),
            .BANK   (gv / VOICES_PER_BANK)
        ) u_voice (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (adv),
            .wr_en   (reg_we),
            .wr_addr (reg_addr),
            .wr_data (reg_wdata),
            .phase_o (phase_all[gv*REG_W +: REG_W]),
            .step_o  (step_all[gv*REG_W +: REG_W]),
            .taddr_o (tbl_addr[gv*TADDR_W +: TADDR_W])
        );
    end

    wm_readback #(
        .NUM_VOICES (NUM_VOICES),
        .ADDR_W     (ADDR_W),
        .VOICE_BASE (VOICE_BASE),
        .MODE_ADDR  (MODE_ADDR)
    ) u_readback (
        .addr      (reg_addr),
        .mode      (ctl_q.mode),
        .phase_all (phase_all),
        .step_all  (step_all),
        .rdata     (reg_rdata)
    );

    wm_mix #(
        .NUM_VOICES (NUM_VOICES),
        .SMP_W      (SMP_W)
    ) u_mix (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (ctl_q.pend),
        .samples (tbl_data),
        .left    (left),
        .right   (right),
        .valid   (out_valid)
    );
endmodule

// File: rtl/wm_checker.sv
module wm_checker #(
    parameter int TA_W  = 40,
    parameter int SMP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             play,
    input logic             reg_we,
    input logic [TA_W-1:0]  tbl_addr,
    input logic [SMP_W-1:0] left,
    input logic [SMP_W-1:0] right,
    input logic             out_valid
);
    a_r6_pulse_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && play) |=> ##1 out_valid)
        else $error("a_r6_pulse_follows_tick");

    a_r6_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(tick && play, 2))
        else $error("a_r6_pulse_needs_tick");

    a_r6_left_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(left))
        else $error("a_r6_left_holds");

    a_r6_right_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(right))
        else $error("a_r6_right_holds");

    a_r7_r8_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && !(tick && play)) |=> $stable(tbl_addr))
        else $error("a_r7_r8_addr_holds");
endmodule

bind wavemix4 wm_checker #(
    .TA_W  (NUM_VOICES * TADDR_W),
    .SMP_W (SMP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .play      (play),
    .reg_we    (reg_we),
    .tbl_addr  (tbl_addr),
    .left      (left),
    .right     (right),
    .out_valid (out_valid)
);

// File: tb/wavemix4_tb.sv
module wavemix4_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 4;
    localparam int TA         = 10;
    localparam int WATCHDOG   = 100000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            tick;
    logic            reg_we;
    logic [7:0]      reg_addr;
    logic [7:0]      reg_wdata;
    logic [7:0]      reg_rdata;
    logic [NV*TA-1:0] tbl_addr;
    logic [NV*8-1:0] tbl_data;
    logic [7:0]      left;
    logic [7:0]      right;
    logic            out_valid;

    int              n_checks = 0;
    int              n_fails  = 0;
    logic [31:0]     mphase [NV];
    logic [31:0]     mstep  [NV];

    always #(CLK_PERIOD/2) clk = ~clk;

    wavemix4 u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tbl_addr  (tbl_addr),
        .tbl_data  (tbl_data),
        .left      (left),
        .right     (right),
        .out_valid (out_valid)
    );

    function automatic logic [7:0] tval(input logic bank, input logic [8:0] idx);
        int t;
        t = int'(idx) * 37 + int'(bank) * 91 + 5;
        return t[7:0];
    endfunction

    // table memory model: combinational read
    always_comb begin
        for (int v = 0; v < NV; v++) begin
            tbl_data[v*8 +: 8] = tval(tbl_addr[v*TA + 9], tbl_addr[v*TA +: 9]);
        end
    end

    function automatic logic [7:0] exp_mix();
        int s;
        s = 0;
        for (int v = 0; v < NV; v++) begin
            s += int'(tval(1'(v / 2), mphase[v][23:15]));
        end
        return 8'(s >> 2);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd32(input logic [7:0] a, output logic [31:0] w);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(a + 8'(i), b);
            w[31-8*i -: 8] = b;
        end
    endtask

    task automatic set_phase(input int v, input logic [31:0] val);
        for (int i = 0; i < 4; i++) wr(8'(16 + 8*v + i), val[31-8*i -: 8]);
        mphase[v] = val;
    endtask

    task automatic set_step(input int v, input logic [31:0] val);
        for (int i = 0; i < 4; i++) wr(8'(20 + 8*v + i), val[31-8*i -: 8]);
        mstep[v] = val;
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] w;
        for (int v = 0; v < NV; v++) begin
            rd32(8'(16 + 8*v), w);
            chk($sformatf("%s phase v%0d", tag, v), w, mphase[v]);
            rd32(8'(20 + 8*v), w);
            chk($sformatf("%s step v%0d", tag, v), w, mstep[v]);
        end
    endtask

    task automatic check_addrs(input string tag);
        for (int v = 0; v < NV; v++) begin
            chk($sformatf("%s tbl_addr v%0d", tag, v), 32'(tbl_addr[v*TA +: TA]),
                32'({1'(v / 2), mphase[v][23:15]}));
        end
    endtask

    task automatic do_tick(input bit expect_play, input string tag);
        logic [7:0] prev;
        logic [7:0] e;
        prev = left;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk({tag, " no pulse one cycle after strobe"}, 32'(out_valid), 32'd0);
        @(negedge clk);
        if (expect_play) begin
            for (int v = 0; v < NV; v++) mphase[v] = mphase[v] + mstep[v];
            e = exp_mix();
            chk({tag, " R6 out_valid"}, 32'(out_valid), 32'd1);
            chk({tag, " R6 left"}, 32'(left), 32'(e));
            chk({tag, " R6 right"}, 32'(right), 32'(e));
        end else begin
            chk({tag, " R7 out_valid"}, 32'(out_valid), 32'd0);
            chk({tag, " R7 left held"}, 32'(left), 32'(prev));
        end
        @(negedge clk);
        chk({tag, " R6 single-cycle pulse"}, 32'(out_valid), 32'd0);
    endtask

    task automatic test_reset();
        logic [7:0] b;
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 left", 32'(left), 32'd0);
        chk("R1 right", 32'(right), 32'd0);
        rd(8'h01, b);
        chk("R1 mode", 32'(b), 32'd0);
        check_regs("R1");
    endtask

    task automatic test_regs();
        logic [7:0]  b;
        logic [31:0] w;
        set_step(1, 32'h1234_5678);
        set_phase(3, 32'hAABB_CCDD);
        rd(8'h1D, b);
        chk("R2 step v1 byte 0x1D", 32'(b), 32'h34);
        rd(8'h28, b);
        chk("R2 phase v3 msb at 0x28", 32'(b), 32'hAA);
        wr(8'h2B, 8'h5A);
        mphase[3][7:0] = 8'h5A;
        rd32(8'h28, w);
        chk("R2 single byte write", w, 32'hAABB_CC5A);
        check_regs("R2");
        set_step(1, 32'h0);
        set_phase(3, 32'h0);
    endtask

    task automatic test_idle();
        set_step(0, 32'h0000_8000);
        set_step(2, 32'h0003_0000);
        wr(8'h01, 8'h01);
        do_tick(1'b0, "R7 mode1");
        check_regs("R7 mode1");
        wr(8'h01, 8'h00);
        do_tick(1'b0, "R7 mode0");
        check_regs("R7 mode0");
    endtask

    task automatic test_mode();
        logic [7:0] b;
        wr(8'h01, 8'hFE);
        rd(8'h01, b);
        chk("R3 upper mode bits dropped", 32'(b), 32'h02);
        do_tick(1'b1, "R3 mode from 0xFE plays");
        check_regs("R3 R4 after tick");
    endtask

    task automatic test_play();
        set_phase(0, 32'h0);
        set_phase(1, 32'h0012_3456);
        set_phase(2, 32'h0100_0000);
        set_phase(3, 32'h00FF_8000);
        set_step(0, 32'h0000_8000);
        set_step(1, 32'h0001_0000);
        set_step(2, 32'h0001_8000);
        set_step(3, 32'h0000_4000);
        for (int k = 0; k < 4; k++) begin
            do_tick(1'b1, $sformatf("R6 play tick %0d", k));
            check_addrs("R5 play");
            check_regs("R4 play");
        end
    endtask

    task automatic test_wrap();
        set_phase(0, 32'hFFFF_FFF0);
        set_step(0, 32'h0000_0020);
        set_phase(2, 32'h7F00_7FFF);
        set_step(2, 32'h0000_0001);
        do_tick(1'b1, "R4 wrap");
        chk("R4 phase wraps modulo 2^32", mphase[0], 32'h0000_0010);
        check_regs("R4 wrap");
        chk("R5 upper bits ignored v2", 32'(tbl_addr[2*TA +: TA]), 32'h201);
        check_addrs("R5 wrap");
    endtask

    task automatic test_pending();
        logic [NV*TA-1:0] a0;
        logic [7:0]       l0;
        a0 = tbl_addr;
        l0 = left;
        set_step(1, 32'h0004_0000);
        chk("R8 addresses unchanged by step write", 32'(tbl_addr[31:0]), 32'(a0[31:0]));
        chk("R8 addresses unchanged by step write hi", 32'(tbl_addr[39:32]), 32'(a0[39:32]));
        chk("R8 left unchanged by step write", 32'(left), 32'(l0));
        chk("R8 no pulse from step write", 32'(out_valid), 32'd0);
        do_tick(1'b1, "R8 new step used");
        check_addrs("R8");
        check_regs("R8");
    endtask

    task automatic test_unmapped();
        logic [7:0] b;
        rd(8'h00, b); chk("R9 read 0x00", 32'(b), 32'd0);
        rd(8'h30, b); chk("R9 read 0x30", 32'(b), 32'd0);
        rd(8'hFF, b); chk("R9 read 0xFF", 32'(b), 32'd0);
        wr(8'h30, 8'hFF);
        wr(8'h02, 8'hFF);
        wr(8'h0F, 8'hFF);
        rd(8'h01, b); chk("R9 mode untouched", 32'(b), 32'h02);
        check_regs("R9");
        do_tick(1'b1, "R9 still plays");
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int v = 0; v < NV; v++) begin
            mphase[v] = '0;
            mstep[v]  = '0;
        end
        rst_n = 1'b0; tick = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_regs();
        test_idle();
        test_mode();
        test_play();
        test_wrap();
        test_pending();
        test_unmapped();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule